// File: doc/BRIEF.md
# Serial Write-Only Mux Control Register

This block is a receive-only target on a two-wire serial bus (I2C). A fast system clock oversamples the clock line and the data line. The block recognises start and stop conditions and accepts one write transfer: an address byte, then exactly one data byte. The received byte sets four 2:1/1:2 switch blocks. Each block takes a select bit and a mode bit from it. Two static pins pick one of four bus addresses. The block answers on the data line only through an open-drain pull-low enable.

The byte is first held in a shadow register. The control outputs change only when the controller ends the transfer with a stop condition. A stop or a repeated start that cuts a byte short leaves the outputs unchanged.

The controller has these states. IDLE waits for a start. ADDR shifts in the address byte. ADDR_ACK pulls the data line low. DATA shifts in the control byte. DATA_ACK pulls the data line low. SKIP ignores the bus.

These are the transitions:
- A start in any state goes to ADDR.
- A stop in any state goes to IDLE.
- ADDR goes to ADDR_ACK on the eighth falling clock edge when the address matches with write direction. It goes to SKIP on that edge otherwise.
- ADDR_ACK goes to DATA on the next falling clock edge.
- DATA goes to DATA_ACK on its eighth falling clock edge.
- DATA_ACK goes to SKIP on the next falling clock edge.

Top module: `i2c_muxctl_slave`

## Requirements
- R1: After reset `ctrl_o` is 0xAA and `sda_oe` is 0. Bit 2k+1 is the mode bit and bit 2k the select bit of switch block k, for k from 0 to 3.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. Bits clocked before any start are never acknowledged.
- R3: The address byte is taken MSB first on rising SCL edges. It matches when its upper seven bits are 1,1,0,1,1,`adr_sel[1]`,`adr_sel[0]` and its last bit (direction) is 0. On a match `sda_oe` is 1 before the ninth rising SCL edge, stays 1 while SCL is high, and is 0 again shortly after that clock falls.
- R4: An address that does not match, or a direction bit of 1, is not acknowledged. The rest of that transfer is ignored, and the stop that ends it leaves `ctrl_o` unchanged.
- R5: After a matched address, the next byte is taken MSB first and acknowledged like the address.
- R6: `ctrl_o` keeps its old value until the stop that follows an acknowledged data byte. It then takes that byte.
- R7: Bytes after the first data byte are not acknowledged and do not change the value committed at the stop.
- R8: A stop in the middle of the data byte leaves `ctrl_o` unchanged. So does a repeated start after the data byte followed by a stop. A later complete transfer still works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| adr_sel | input | 2 | Low two address bits |
| sda_oe | output | 1 | 1 pulls the data line low |
| ctrl_o | output | 8 | Committed switch control byte |

## Verification
The hardest cases to reach are the aborts. A stop or a repeated start must land while the byte counter is part-way through, or just after the data acknowledge, and only a commit that does not happen shows the result. The bench models the bus as a wired-AND of the controller's line and `sda_oe`. Its bit tasks can stop after any number of bits, so stops and repeated starts are placed mid-byte and after the acknowledge. `ctrl_o` is then compared with the value it held before.

// File: rtl/i2c_muxctl_pkg.sv
package i2c_muxctl_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } xfer_state_t;
endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic scl_d;
    logic sda_d;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain[g] <= 1'b1;
                    sda_chain[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_chain[g] <= scl_raw;
                    sda_chain[g] <= sda_raw;
                end else begin
                    scl_chain[g] <= scl_chain[(g == 0) ? 0 : g - 1];
                    sda_chain[g] <= sda_chain[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign scl_s = scl_chain[SYNC_STAGES-1];
    assign sda_s = sda_chain[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2c_ctrl_store.sv
module i2c_ctrl_store #(
    parameter int             WIDTH     = 8,
    parameter logic [WIDTH-1:0] RESET_VAL = 8'hAA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic             commit,
    output logic [WIDTH-1:0] ctrl
);
    logic [WIDTH-1:0] shadow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= RESET_VAL;
            ctrl   <= RESET_VAL;
        end else begin
            if (load_en) shadow <= load_val;
            if (commit)  ctrl   <= shadow;
        end
    end
endmodule

// File: rtl/i2c_muxctl_slave.sv
module i2c_muxctl_slave
    import i2c_muxctl_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [4:0]  ADDR_HIGH   = 5'b11011,
    parameter logic [7:0]  CTRL_RESET  = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] adr_sel,
    output logic       sda_oe,
    output logic [7:0] ctrl_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    xfer_state_t state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              data_ok;
    logic              byte_done;
    logic              addr_hit;
    logic              load_en;
    logic              commit;

    i2c_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_i),
        .sda_raw  (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    assign byte_done = scl_fall && (bit_cnt == CNT_W'(BYTE_W));
    assign addr_hit  = (shreg[7:1] == {ADDR_HIGH, adr_sel}) && !shreg[0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall)  state_nx = ST_DATA;
                ST_DATA:     if (byte_done) state_nx = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall)  state_nx = ST_SKIP;
                ST_SKIP:     state_nx = ST_SKIP;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // bit counter, shifter and pending flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            data_ok <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
            data_ok <= 1'b0;
        end else begin
            if ((state == ST_ADDR || state == ST_DATA) && scl_rise
                && bit_cnt < CNT_W'(BYTE_W)) begin
                shreg   <= {shreg[BYTE_W-2:0], sda_s};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (state == ST_ADDR_ACK && scl_fall) bit_cnt <= '0;
            if (load_en) data_ok <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        sda_oe  = (state == ST_ADDR_ACK) || (state == ST_DATA_ACK);
        load_en = (state == ST_DATA) && byte_done && !start_det && !stop_det;
        commit  = stop_det && data_ok;
    end

    i2c_ctrl_store #(.WIDTH(BYTE_W), .RESET_VAL(CTRL_RESET)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .load_val(shreg),
        .commit  (commit),
        .ctrl    (ctrl_o)
    );
endmodule

// File: rtl/i2c_muxctl_chk.sv
module i2c_muxctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe,
    input logic [7:0] ctrl_o
);
    // R1
    reset_value_chk: assert property (@(posedge clk) !rst_n |=> (ctrl_o == 8'hAA && !sda_oe));

    // R2
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R3
    ack_drive_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R3
    ack_release_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    // R6
    commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_det |=> $stable(ctrl_o));
endmodule

bind i2c_muxctl_slave i2c_muxctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .ctrl_o   (ctrl_o)
);

// File: tb/i2c_muxctl_slave_test.sv
module i2c_muxctl_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] adr_sel = 2'b11;
    logic sda_oe;
    logic [7:0] ctrl_o;
    logic sda_line;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_muxctl_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .adr_sel(adr_sel), .sda_oe(sda_oe), .ctrl_o(ctrl_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    // returns 1 when the line was low just before and during the ninth clock
    task automatic ack_bit(output logic acked, output logic released_after);
        logic pre, mid;
        sda_m = 1'b1; wq();
        pre = sda_line;
        scl_m = 1'b1; wq();
        mid = sda_line; wq();
        scl_m = 1'b0; wq();
        released_after = sda_line;
        acked = !pre && !mid;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic rel;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        ack_bit(acked, rel);
    endtask

    task automatic t_reset();
        check("R1 reset ctrl", ctrl_o, 8'hAA);
        check("R1 reset oe", sda_oe, 1'b0);
    endtask

    task automatic t_basic_write();
        logic a, rel, d;
        adr_sel = 2'b11;
        bus_start();
        for (int i = 7; i >= 0; i--) send_bit(8'hDE >> i);
        ack_bit(a, rel);
        check("R3 addr ack 0x6F", a, 1'b1);
        check("R3 ack released", rel, 1'b1);
        send_byte(8'h55, d);
        check("R5 data ack", d, 1'b1);
        check("R6 held before stop", ctrl_o, 8'hAA);
        bus_stop();
        check("R6 committed at stop", ctrl_o, 8'h55);
    endtask

    task automatic t_pins_and_mismatch();
        logic a, d;
        adr_sel = 2'b00;
        bus_start(); send_byte(8'hD8, a); send_byte(8'h3C, d); bus_stop();
        check("R3 addr ack 0x6C", a, 1'b1);
        check("R5 data 0x3C", ctrl_o, 8'h3C);
        bus_start(); send_byte(8'hDE, a); send_byte(8'h99, d); bus_stop();
        check("R4 mismatch nack", a, 1'b0);
        check("R4 mismatch data nack", d, 1'b0);
        check("R4 mismatch no change", ctrl_o, 8'h3C);
    endtask

    task automatic t_read_bit();
        logic a, d;
        adr_sel = 2'b01;
        bus_start(); send_byte(8'hDB, a); send_byte(8'h11, d); bus_stop();
        check("R4 read nack", a, 1'b0);
        check("R4 read no change", ctrl_o, 8'h3C);
    endtask

    task automatic t_no_start();
        logic a;
        adr_sel = 2'b01;
        send_byte(8'hDA, a);
        check("R2 no ack without start", a, 1'b0);
        check("R2 oe idle", sda_oe, 1'b0);
        bus_stop();
        check("R2 no change", ctrl_o, 8'h3C);
    endtask

    task automatic t_extra_bytes();
        logic a, d, e;
        adr_sel = 2'b10;
        bus_start(); send_byte(8'hDC, a); send_byte(8'h81, d); send_byte(8'hFF, e); bus_stop();
        check("R7 first data ack", d, 1'b1);
        check("R7 extra nack", e, 1'b0);
        check("R7 first byte kept", ctrl_o, 8'h81);
    endtask

    task automatic t_aborts();
        logic a, d;
        adr_sel = 2'b10;
        bus_start(); send_byte(8'hDC, a);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        check("R8 mid-byte stop", ctrl_o, 8'h81);
        bus_start(); send_byte(8'hDC, a); send_byte(8'h00, d);
        bus_start(); bus_stop();
        check("R8 repeated start discards", ctrl_o, 8'h81);
        bus_start(); send_byte(8'hDC, a); send_byte(8'h6A, d); bus_stop();
        check("R8 recovery write", ctrl_o, 8'h6A);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_basic_write();
        t_pins_and_mismatch();
        t_read_bit();
        t_no_start();
        t_extra_bytes();
        t_aborts();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule